// File: doc/BRIEF.md
# Scan-Based Bit Control Unit

This block carries out the bit-control instructions of a ladder-logic scan engine on a bank of operand bits. A sequencer walks through the program one instruction per clock. For each instruction it presents a request to this block. The request names the operation, the operand bit it targets, an execution condition, and, for the latch operation, a second condition that acts as the reset input. A separate strobe marks the boundary between one program scan and the next.

Edge-sensitive operations are measured in scans, not in clocks. Each of the 16 instruction slots has its own history of the condition it saw in the previous scan, and the history advances only on the scan strobe. A pulse produced by a differentiate operation therefore stays on until the same instruction runs again in the following scan. The latched operation keeps its bit across any number of scans. When the latch sees both of its inputs at once, the reset input wins. The current operand bits are always visible on the output port.

Top module: `scan_bit_ctrl`

## Requirements
- R1: Operation code 0 (force-on) drives the addressed bit to 1 in the cycle after the request when the condition is 1, and leaves the bit unchanged when the condition is 0.
- R2: Operation code 1 (force-off) drives the addressed bit to 0 in the cycle after the request when the condition is 1, and leaves the bit unchanged when the condition is 0.
- R3: Operation code 2 (rising pulse) writes the addressed bit to 1 when the condition is 1 and the slot history is 0. In every other case it writes the bit to 0, so the bit stays on for exactly one scan.
- R4: Operation code 3 (falling pulse) writes the addressed bit to 1 when the condition is 0 and the slot history is 1. In every other case it writes the bit to 0.
- R5: Operation code 4 (latch) uses req_cond as its set input and req_cond_rst as its reset input. With only the set input at 1, the bit becomes 1. With both inputs at 0, the bit holds its value.
- R6: When the latch reset input is 1, the bit becomes 0, whatever the value of the set input.
- R7: Each slot records the last condition given to it by a code 2 or 3 request. That record is copied into the slot history only on a cycle with scan_tick at 1, in the same cycle as any request applied with it. Slots do not affect one another.
- R8: A synchronous reset clears all operand bits and every slot history. A rising-pulse condition that is already 1 in the first scan after reset therefore yields a 1.
- R9: Requests with req_valid at 0, or with operation codes 5 to 7, change no operand bit.
- R10: A request changes at most the one bit selected by req_bit. All other bits keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_tick | input | 1 | End-of-scan strobe; commits slot histories |
| req_valid | input | 1 | Request present this cycle |
| req_slot | input | 4 | Instruction slot owning the edge history |
| req_kind | input | 3 | Operation code (0..4 defined) |
| req_bit | input | 5 | Operand bit index |
| req_cond | input | 1 | Execution condition; set input for the latch |
| req_cond_rst | input | 1 | Reset input for the latch |
| bits_out | output | 32 | Current operand bit values |

## Verification
The assertions assume that every request input is at a known value once reset is released. They also assume that reset is held for at least one clock edge, so the one-bit-change and idle-stability checks compare against a cleared bank. They further assume that each slot number stands for a single differentiate instance, so its history has one meaning. The stimulus meets these assumptions. It drives every input on the falling edge from a fixed idle state, holds reset for several cycles, and uses separate slots for separate edge instructions in the directed scans. The random phase deliberately lets a few slots and bits collide, to exercise interactions that the reference model in the bench tracks.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    typedef enum logic [2:0] {
        K_SET   = 3'd0,
        K_CLR   = 3'd1,
        K_RISE  = 3'd2,
        K_FALL  = 3'd3,
        K_LATCH = 3'd4
    } bit_op_e;

    typedef struct packed {
        logic en;
        logic val;
    } bit_wr_t;

    function automatic logic is_edge_op(input logic [2:0] kind);
        return (kind == K_RISE) || (kind == K_FALL);
    endfunction

    function automatic bit_wr_t eval_op(input logic [2:0] kind,
                                        input logic       c,
                                        input logic       cr,
                                        input logic       h);
        bit_wr_t w;
        w = '{1'b0, 1'b0};
        case (kind)
            K_SET:   w = '{c, 1'b1};
            K_CLR:   w = '{c, 1'b0};
            K_RISE:  w = '{1'b1, c & ~h};
            K_FALL:  w = '{1'b1, ~c & h};
            K_LATCH: begin
                if (cr)     w = '{1'b1, 1'b0};
                else if (c) w = '{1'b1, 1'b1};
            end
            default: w = '{1'b0, 1'b0};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/bcu_slot_hist.sv
module bcu_slot_hist #(
    parameter int NSLOTS = 16,
    parameter int SLOTW  = $clog2(NSLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             upd_en,
    input  logic [SLOTW-1:0] upd_slot,
    input  logic             upd_cond,
    input  logic [SLOTW-1:0] rd_slot,
    output logic             rd_hist
);

    logic [NSLOTS-1:0] cur_q;
    logic [NSLOTS-1:0] hist_q;

    for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
        logic hit;
        logic cur_nx;
        assign hit    = upd_en && (upd_slot == SLOTW'(i));
        assign cur_nx = hit ? upd_cond : cur_q[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                cur_q[i]  <= 1'b0;
                hist_q[i] <= 1'b0;
            end else begin
                cur_q[i] <= cur_nx;
                if (tick) hist_q[i] <= cur_nx;
            end
        end
    end

    assign rd_hist = hist_q[rd_slot];

    // R7: history only advances on the scan strobe
    a_r7_hist_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(hist_q));

    // R7: no edge update and no tick leaves the pending record alone
    a_r7_cur_hold: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(cur_q));

endmodule

// File: rtl/bcu_op_eval.sv
module bcu_op_eval
    import bcu_pkg::*;
(
    input  logic       valid,
    input  logic [2:0] kind,
    input  logic       cond,
    input  logic       cond_rst,
    input  logic       hist,
    output bit_wr_t    wr,
    output logic       hist_upd
);

    bit_wr_t raw;

    always_comb begin
        raw      = eval_op(kind, cond, cond_rst, hist);
        wr.en    = valid & raw.en;
        wr.val   = raw.val;
        hist_upd = valid & is_edge_op(kind);
    end

    // R9: undefined codes never request a write
    always_comb begin
        if (valid && kind > 3'd4)
            a_r9_undef_no_write: assert (!wr.en);
    end

endmodule

// File: rtl/bcu_bit_mem.sv
module bcu_bit_mem #(
    parameter int NBITS = 32,
    parameter int IDXW  = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic             wr_val,
    output logic [NBITS-1:0] bits
);

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                bits[i] <= 1'b0;
            else if (wr_en && wr_idx == IDXW'(i))
                bits[i] <= wr_val;
        end
    end

    // R10: at most one operand bit moves per cycle
    a_r10_single_bit: assert property (@(posedge clk) disable iff (rst)
        $countones(bits ^ $past(bits)) <= 1);

endmodule

// File: rtl/scan_bit_ctrl.sv
module scan_bit_ctrl
    import bcu_pkg::*;
#(
    parameter int NBITS  = 32,
    parameter int NSLOTS = 16,
    localparam int IDXW  = $clog2(NBITS),
    localparam int SLOTW = $clog2(NSLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_tick,
    input  logic             req_valid,
    input  logic [SLOTW-1:0] req_slot,
    input  logic [2:0]       req_kind,
    input  logic [IDXW-1:0]  req_bit,
    input  logic             req_cond,
    input  logic             req_cond_rst,
    output logic [NBITS-1:0] bits_out
);

    logic    slot_hist;
    logic    hist_upd;
    bit_wr_t wr;

    bcu_slot_hist #(.NSLOTS(NSLOTS), .SLOTW(SLOTW)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .tick     (scan_tick),
        .upd_en   (hist_upd),
        .upd_slot (req_slot),
        .upd_cond (req_cond),
        .rd_slot  (req_slot),
        .rd_hist  (slot_hist)
    );

    bcu_op_eval u_eval (
        .valid    (req_valid),
        .kind     (req_kind),
        .cond     (req_cond),
        .cond_rst (req_cond_rst),
        .hist     (slot_hist),
        .wr       (wr),
        .hist_upd (hist_upd)
    );

    bcu_bit_mem #(.NBITS(NBITS), .IDXW(IDXW)) u_mem (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr.en),
        .wr_idx (req_bit),
        .wr_val (wr.val),
        .bits   (bits_out)
    );

    a_r1_set_on: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == K_SET && req_cond
        |=> bits_out[$past(req_bit)] == 1'b1);

    a_r2_clr_off: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == K_CLR && req_cond
        |=> bits_out[$past(req_bit)] == 1'b0);

    a_r3_rise_pulse: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == K_RISE && req_cond && !slot_hist
        |=> bits_out[$past(req_bit)] == 1'b1);

    a_r4_fall_quiet: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == K_FALL && req_cond
        |=> bits_out[$past(req_bit)] == 1'b0);

    a_r5_latch_hold: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == K_LATCH && !req_cond && !req_cond_rst
        |=> $stable(bits_out));

    a_r6_reset_wins: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == K_LATCH && req_cond_rst
        |=> bits_out[$past(req_bit)] == 1'b0);

    a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(bits_out));

endmodule

// File: tb/scan_bit_ctrl_test.sv
module scan_bit_ctrl_test;

    logic        clk = 1'b0;
    logic        rst, scan_tick, req_valid, req_cond, req_cond_rst;
    logic [3:0]  req_slot;
    logic [2:0]  req_kind;
    logic [4:0]  req_bit;
    logic [31:0] bits_out;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_bits = '0;
    logic [15:0] m_cur  = '0;
    logic [15:0] m_hist = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    scan_bit_ctrl uut (
        .clk(clk), .rst(rst), .scan_tick(scan_tick), .req_valid(req_valid),
        .req_slot(req_slot), .req_kind(req_kind), .req_bit(req_bit),
        .req_cond(req_cond), .req_cond_rst(req_cond_rst), .bits_out(bits_out)
    );

    task automatic drive_idle();
        req_valid = 0; scan_tick = 0; req_slot = 0; req_kind = 0;
        req_bit = 0; req_cond = 0; req_cond_rst = 0;
    endtask

    // driver: applies one request and pushes the expected bank
    task automatic step(input logic v, input logic [3:0] s, input logic [2:0] k,
                        input logic [4:0] b, input logic c, input logic cr,
                        input logic t, input string tag);
        @(negedge clk);
        req_valid = v; req_slot = s; req_kind = k; req_bit = b;
        req_cond = c; req_cond_rst = cr; scan_tick = t;
        if (v) begin
            case (k)
                3'd0: if (c) m_bits[b] = 1'b1;
                3'd1: if (c) m_bits[b] = 1'b0;
                3'd2: begin m_bits[b] = c & ~m_hist[s]; m_cur[s] = c; end
                3'd3: begin m_bits[b] = ~c & m_hist[s]; m_cur[s] = c; end
                3'd4: begin
                    if (cr) m_bits[b] = 1'b0;
                    else if (c) m_bits[b] = 1'b1;
                end
                default: ;
            endcase
        end
        if (t) m_hist = m_cur;
        exp_q.push_back(m_bits);
        tag_q.push_back(tag);
    endtask

    // monitor: pops and compares after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if (bits_out !== e) begin
                    errors++;
                    $display("FAIL %s: bits_out=%h expected %h", tg, bits_out, e);
                end
            end
        end
    end

    task automatic check_reset(input string tag);
        @(negedge clk);
        checks++;
        if (bits_out !== 32'h0) begin
            errors++;
            $display("FAIL %s: bits_out=%h expected %h", tag, bits_out, 32'h0);
        end
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        rst = 1'b1;
        drive_idle();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        check_reset("R8 reset state");

        // R8 / R3: first scan sees a rising edge
        step(1, 0, 2, 3, 1, 0, 0, "R8 first-scan rise");
        step(0, 0, 0, 0, 0, 0, 1, "R7 tick only");
        step(1, 0, 2, 3, 1, 0, 0, "R3 pulse ends next scan");
        step(1, 0, 2, 3, 0, 0, 1, "R3 cond low");
        step(1, 0, 2, 3, 1, 0, 1, "R3 second rise");
        // R1 / R2
        step(1, 5, 0, 5, 1, 0, 0, "R1 force-on");
        step(1, 5, 0, 5, 0, 0, 0, "R1 cond low holds");
        step(1, 5, 1, 5, 0, 0, 0, "R2 cond low holds");
        step(1, 5, 1, 5, 1, 0, 0, "R2 force-off");
        // R4
        step(1, 1, 3, 4, 1, 0, 1, "R4 high gives no pulse");
        step(1, 1, 3, 4, 0, 0, 1, "R4 falling pulse");
        step(1, 1, 3, 4, 0, 0, 1, "R4 pulse one scan");
        // R5 / R6
        step(1, 6, 4, 7, 1, 0, 0, "R5 latch set");
        step(1, 6, 4, 7, 0, 0, 1, "R5 latch hold");
        step(1, 6, 4, 7, 1, 1, 0, "R6 both on reset wins");
        step(1, 6, 4, 7, 0, 0, 0, "R5 latch hold low");
        step(1, 6, 4, 7, 1, 0, 0, "R5 latch set again");
        step(1, 6, 4, 7, 0, 1, 0, "R6 reset only");
        step(1, 6, 4, 7, 1, 0, 0, "R5 latch set third");
        // R9
        step(1, 2, 6, 7, 1, 1, 0, "R9 code 6 ignored");
        step(1, 2, 5, 8, 1, 0, 0, "R9 code 5 ignored");
        step(1, 2, 7, 7, 1, 1, 0, "R9 code 7 ignored");
        step(0, 2, 1, 7, 1, 1, 0, "R9 valid low ignored");
        // R7 slot independence
        step(1, 2, 2, 8, 1, 0, 0, "R7 slot2 rise");
        step(1, 2, 2, 8, 1, 0, 0, "R7 same scan no commit");
        step(1, 3, 2, 9, 0, 0, 1, "R7 other slot with tick");
        step(1, 2, 2, 8, 1, 0, 0, "R7 after commit");
        step(1, 3, 2, 9, 1, 0, 0, "R7 slot3 own history");
        // R10 mixed random traffic
        r = 32'h1234_5679;
        for (int n = 0; n < 600; n++) begin
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            step(r[0] | r[1], {2'b00, r[3:2]}, r[6:4], {2'b00, r[9:7]},
                 r[10], r[11] & r[12], r[13] & r[14], "R10 random traffic");
        end
        @(negedge clk);
        drive_idle();
        repeat (3) @(negedge clk);

        // R8 mid-run reset clears bits and history
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_bits = '0; m_cur = '0; m_hist = '0;
        check_reset("R8 reset after traffic");
        step(1, 0, 2, 3, 1, 0, 0, "R8 history cleared by reset");
        step(1, 1, 3, 4, 0, 0, 0, "R8 no falling pulse after reset");
        @(negedge clk);
        drive_idle();
        repeat (3) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule